// File: doc/BRIEF.md
# Card Boot Reset Sequencer and Low-Memory Overlay

This block owns the processor's reset line. After power-up or a restart request it keeps the processor in reset and prepares a removable flash card, which presents an ATA-style task-file register set, to deliver its first logical block. It waits for the card to become idle, loads a one-sector read of logical block 0 in LBA addressing, starts the read, and waits until the card offers data. Only then does it let the processor run.

Once the processor runs, every memory access to the lowest 256 addresses is steered to the card's 16-bit data register rather than to RAM. The first instructions therefore stream straight out of the boot sector, and no boot ROM is needed. The loader disables this overlay by writing to a control I/O port once it has copied itself elsewhere, and the low addresses then return to RAM.

A jumper chooses between this card boot and a serial-strap boot. In strap mode the card is left alone, the overlay stays off, and the block presents a fixed strap code while it holds the processor in reset for a set time. Each status wait is bounded. A card that never becomes ready raises an error flag and leaves the processor in reset.

Top module: `cf_boot_streamer`

## Requirements
- R1: While `rst_n` is low, `cpu_reset_n` is low. One cycle after a `reset_req` pulse, `cpu_reset_n` is low and the whole boot sequence begins again from the start.
- R2: `boot_sel` is sampled only when a restart begins (1 = card boot, 0 = strap boot). Changing it later has no effect on the steering or the strap outputs until the next restart.
- R3: In card boot the block first reads the status register (index 7) every cycle. It issues no register write until a read shows BSY (status bit 7) clear.
- R4: After the idle wait the block makes exactly six single-cycle register writes, in this order: index 2 ← 0x01, index 3 ← 0x00, index 4 ← 0x00, index 5 ← 0x00, index 6 ← 0xE0 (LBA mode, drive 0), index 7 ← 0x20 (read sector). It writes nothing else while the processor is held.
- R5: It then reads status every cycle. `cpu_reset_n` rises on the clock edge that follows the first read showing BSY clear and DRQ (status bit 3) set.
- R6: Each status wait lasts at most `TIMEOUT` reads. When a wait expires, `arm_error` is set, and both it and the low `cpu_reset_n` stay until the next restart. With `TIMEOUT` = 60 and a card that never goes idle, `arm_error` first shows in the 61st cycle after the restart cycle.
- R7: After a card boot, a memory access with address below 0x100 asserts `card_sel`, strobes `cf_stb` with `cf_reg` = 0 and `cf_we` equal to `cpu_wr`, and keeps `ram_sel` low. Every other memory access asserts `ram_sel` only.
- R8: An I/O write whose low address byte equals `CTRL_PORT` (0xF0 by default) turns the overlay off from the next cycle on. An I/O write to any other port leaves it on. A restart in card mode turns it on again.
- R9: In strap boot the card sees no strobe. `strap_en` is high with `strap_data` = 0x40 for the `STRAP_HOLD` cycles of the hold and for the first cycle after release, then low. `cpu_reset_n` rises after exactly `STRAP_HOLD` hold cycles, and the low addresses go to RAM.
- R10: While `cpu_reset_n` is low, `ram_sel` and `card_sel` stay low whatever the processor bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req | input | 1 | Synchronous restart request from the reset button |
| boot_sel | input | 1 | Jumper: 1 card boot, 0 strap boot |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_mreq | input | 1 | Processor memory access strobe |
| cpu_iorq | input | 1 | Processor I/O access strobe |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_reset_n | output | 1 | Processor reset, active low |
| arm_error | output | 1 | A card status wait timed out |
| ram_sel | output | 1 | Steer the current memory access to RAM |
| card_sel | output | 1 | Steer the current memory access to the card data register |
| strap_en | output | 1 | Assert the strap wait and drive the strap code |
| strap_data | output | 8 | Strap code placed on the data bus |
| cf_stb | output | 1 | Card register access strobe |
| cf_we | output | 1 | Card register access is a write |
| cf_reg | output | 3 | Card register index |
| cf_wdata | output | DATA_W | Card register write data |
| cf_rdata | input | DATA_W | Card register read data; bits 7 and 3 carry BSY and DRQ |

## Verification
On every cycle the assertions check that a restart pulls reset low, that the first task-file write follows an idle status read, that release comes only after a read showing data ready, that an error stays latched, that the overlay is off after a control-port write, and that the strap code is present when a strap boot releases. The full write order, the exact release and timeout cycles, the ignored jumper change, the port decode that leaves the overlay on, and the re-enable after a restart are shown only by the bench. It reaches these through card models with random busy times and through random and boundary addresses.

// File: rtl/cf_boot_streamer.sv
module cf_boot_streamer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int OVL_SIZE = 256,
  parameter int TIMEOUT = 100000,
  parameter int STRAP_HOLD = 16,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'hF0,
  parameter logic [7:0] STRAP_CODE = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              boot_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_mreq,
  input  logic              cpu_iorq,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_reset_n,
  output logic              arm_error,
  output logic              ram_sel,
  output logic              card_sel,
  output logic              strap_en,
  output logic [7:0]        strap_data,
  output logic              cf_stb,
  output logic              cf_we,
  output logic [2:0]        cf_reg,
  output logic [DATA_W-1:0] cf_wdata,
  input  logic [DATA_W-1:0] cf_rdata
);
  localparam int CNT_MAX = (TIMEOUT > STRAP_HOLD) ? TIMEOUT : STRAP_HOLD;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int OVL_W = $clog2(OVL_SIZE);
  localparam logic [2:0] REG_STATUS = 3'd7;
  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] LAST_STEP = 3'd5;

  typedef enum logic [2:0] {
    ST_START, ST_WAIT_IDLE, ST_ARM, ST_WAIT_DATA, ST_STRAP, ST_RUN, ST_FAULT
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       step;
  logic             mode_card;
  logic             overlay;
  logic             strap_q;

  function automatic logic [7:0] arm_byte(input logic [2:0] s);
    case (s)
      3'd0:    arm_byte = 8'h01;
      3'd4:    arm_byte = 8'hE0;
      3'd5:    arm_byte = 8'h20;
      default: arm_byte = 8'h00;
    endcase
  endfunction

  wire st_bsy   = cf_rdata[7];
  wire st_drq   = cf_rdata[3];
  wire polling  = (state == ST_WAIT_IDLE) || (state == ST_WAIT_DATA);
  wire arming   = (state == ST_ARM);
  wire poll_ok  = (state == ST_WAIT_IDLE) ? !st_bsy : (!st_bsy && st_drq);
  wire expired  = (cnt == CNT_W'(TIMEOUT - 1));
  wire hold_end = (cnt == CNT_W'(STRAP_HOLD - 1));
  wire running  = (state == ST_RUN);
  wire low_hit  = (cpu_addr[ADDR_W-1:OVL_W] == '0);
  wire ctrl_hit = cpu_iorq && cpu_wr && (cpu_addr[PORT_W-1:0] == CTRL_PORT);

  logic unused_status;
  assign unused_status = ^{cf_rdata[DATA_W-1:8], cf_rdata[6:4], cf_rdata[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_START;
      cnt       <= '0;
      step      <= '0;
      mode_card <= 1'b0;
      overlay   <= 1'b0;
      strap_q   <= 1'b0;
    end else begin
      strap_q <= (state == ST_STRAP);
      if (reset_req) begin
        state   <= ST_START;
        cnt     <= '0;
        step    <= '0;
        overlay <= 1'b0;
      end else begin
        case (state)
          ST_START: begin
            mode_card <= boot_sel;
            overlay   <= boot_sel;
            cnt       <= '0;
            step      <= '0;
            state     <= boot_sel ? ST_WAIT_IDLE : ST_STRAP;
          end
          ST_WAIT_IDLE, ST_WAIT_DATA: begin
            if (poll_ok) begin
              cnt   <= '0;
              state <= (state == ST_WAIT_IDLE) ? ST_ARM : ST_RUN;
            end else if (expired) begin
              state <= ST_FAULT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ARM: begin
            if (step == LAST_STEP) begin
              step  <= '0;
              state <= ST_WAIT_DATA;
            end else begin
              step <= step + 1'b1;
            end
          end
          ST_STRAP: begin
            if (hold_end) begin
              cnt   <= '0;
              state <= ST_RUN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RUN: if (ctrl_hit) overlay <= 1'b0;
          default: state <= ST_FAULT;
        endcase
      end
    end
  end

  assign cpu_reset_n = running;
  assign arm_error   = (state == ST_FAULT);
  assign card_sel    = running && cpu_mreq && overlay && low_hit;
  assign ram_sel     = running && cpu_mreq && !card_sel;
  assign strap_en    = !mode_card && ((state == ST_STRAP) || strap_q);
  assign strap_data  = strap_en ? STRAP_CODE : 8'h00;

  assign cf_stb   = polling || arming || card_sel;
  assign cf_we    = arming || (card_sel && cpu_wr);
  assign cf_reg   = polling ? REG_STATUS : (arming ? step + 3'd2 : REG_DATA);
  assign cf_wdata = arming ? {{(DATA_W-8){1'b0}}, arm_byte(step)} : cpu_wdata;

  assert_restart_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !cpu_reset_n);

  assert_first_write_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_stb && cf_we && !cpu_reset_n && cf_reg == 3'd2)
      |-> $past(cf_stb && !cf_we && cf_reg == REG_STATUS && !cf_rdata[7]));

  assert_release_after_drq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_reset_n) && mode_card)
      |-> $past(cf_stb && !cf_we && cf_reg == REG_STATUS && cf_rdata[3] && !cf_rdata[7]));

  assert_error_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_error && !reset_req) |=> (arm_error && !cpu_reset_n));

  assert_overlay_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reset_n && ctrl_hit && !reset_req) |=> !card_sel);

  assert_strap_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_reset_n) && !mode_card) |-> (strap_en && strap_data == STRAP_CODE && !cf_stb));
endmodule

// File: tb/sim_cf_boot_streamer.sv
module sim_cf_boot_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 60;
  localparam int HOLD = 12;
  localparam logic [7:0] PORT = 8'hF0;

  logic clk = 0, rst_n = 0, reset_req = 0, boot_sel = 1;
  logic [15:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_mreq = 0, cpu_iorq = 0, cpu_wr = 0;
  logic cpu_reset_n, arm_error, ram_sel, card_sel, strap_en, cf_stb, cf_we;
  logic [7:0] strap_data;
  logic [2:0] cf_reg;
  logic [15:0] cf_wdata, cf_rdata;

  cf_boot_streamer #(.TIMEOUT(TMO), .STRAP_HOLD(HOLD)) u0 (
    .clk, .rst_n, .reset_req, .boot_sel, .cpu_addr, .cpu_mreq, .cpu_iorq, .cpu_wr,
    .cpu_wdata, .cpu_reset_n, .arm_error, .ram_sel, .card_sel, .strap_en, .strap_data,
    .cf_stb, .cf_we, .cf_reg, .cf_wdata, .cf_rdata);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // card model
  bit model_clr = 0, hang_bsy = 0, hang_drq = 0, drq_pend = 0, bsy_at_first = 0;
  int init_busy = 0, cmd_delay = 1, bsy_left = 0, nw = 0, hold_strobes = 0;
  logic [2:0] wreg [8];
  logic [15:0] wdat [8];
  wire bsy = hang_bsy || (bsy_left > 0);
  wire drq = drq_pend && (bsy_left == 0) && !hang_drq;
  assign cf_rdata = {8'h00, bsy, 1'b1, 2'b00, drq, 3'b000};

  always @(posedge clk) begin
    if (model_clr) begin
      bsy_left <= init_busy; drq_pend <= 0; nw <= 0; hold_strobes <= 0;
    end else begin
      if (bsy_left > 0) bsy_left <= bsy_left - 1;
      if (cf_stb && !cpu_reset_n) hold_strobes <= hold_strobes + 1;
      if (cf_stb && cf_we && !cpu_reset_n) begin
        if (nw < 8) begin wreg[nw] <= cf_reg; wdat[nw] <= cf_wdata; end
        if (nw == 0) bsy_at_first <= bsy;
        nw <= nw + 1;
        if (cf_reg == 3'd7 && cf_wdata[7:0] == 8'h20) begin
          bsy_left <= cmd_delay; drq_pend <= 1;
        end
      end
    end
  end

  function automatic bit exp_card(input logic [15:0] a, input bit ovl);
    return ovl && (a < 16'h0100);
  endfunction
  function automatic logic [2:0] exp_reg(input int i);
    return 3'(i + 2);
  endfunction
  function automatic logic [7:0] exp_byte(input int i);
    return (i == 0) ? 8'h01 : (i == 4) ? 8'hE0 : (i == 5) ? 8'h20 : 8'h00;
  endfunction

  task automatic restart(input bit sel, input int ib, input int cd);
    @(negedge clk);
    boot_sel = sel; init_busy = ib; cmd_delay = cd; reset_req = 1; model_clr = 1;
    cpu_mreq = 0; cpu_iorq = 0; cpu_wr = 0;
    @(negedge clk);
    reset_req = 0; model_clr = 0;
    check(cpu_reset_n == 0, "R1", "cpu_reset_n after restart", cpu_reset_n, 0);
  endtask

  // runs until release or error; returns cycle index and drq-first index
  task automatic run_hold(output int rel_at, output int err_at, output int drq_at);
    rel_at = -1; err_at = -1; drq_at = -1;
    for (int n = 0; n < 1000; n++) begin
      @(negedge clk);
      cpu_addr = 16'($urandom_range(0, 16'h01FF)); cpu_mreq = 1; cpu_wr = 1'($urandom);
      #1;
      if (cpu_reset_n) begin rel_at = n; break; end
      if (ram_sel || card_sel) check(0, "R10", "steer while held", {ram_sel, card_sel}, 0);
      if (drq && drq_at < 0) drq_at = n;
      if (arm_error) begin err_at = n; break; end
    end
    cpu_mreq = 0; cpu_wr = 0;
  endtask

  task automatic probe(input logic [15:0] a, input bit ovl, input string req);
    bit w, ec;
    @(negedge clk);
    w = 1'($urandom);
    cpu_addr = a; cpu_mreq = 1; cpu_wr = w;
    #1;
    ec = exp_card(a, ovl);
    check(card_sel == ec && ram_sel == !ec, req, "steering", {card_sel, ram_sel}, {ec, !ec});
    if (ec) check(cf_stb && cf_reg == 3'd0 && cf_we == w, req, "card data access",
                  {cf_stb, cf_reg, cf_we}, {1'b1, 3'd0, w});
    @(negedge clk);
    cpu_mreq = 0; cpu_wr = 0;
  endtask

  task automatic io_write(input logic [7:0] port);
    @(negedge clk);
    cpu_addr = {8'h00, port}; cpu_iorq = 1; cpu_wr = 1;
    @(negedge clk);
    cpu_iorq = 0; cpu_wr = 0;
  endtask

  task automatic card_boot(input int ib, input int cd);
    int rel, err, dq;
    restart(1, ib, cd);
    run_hold(rel, err, dq);
    check(rel >= 0 && err < 0, "R5", "released", rel, 1);
    check(rel == dq + 1, "R5", "release cycle after drq", rel, dq + 1);
    check(bsy_at_first == 0, "R3", "busy at first write", bsy_at_first, 0);
    check(nw == 6, "R4", "write count", nw, 6);
    for (int i = 0; i < 6; i++)
      check(wreg[i] == exp_reg(i) && wdat[i][7:0] == exp_byte(i), "R4", "write order",
            {wreg[i], wdat[i][7:0]}, {exp_reg(i), exp_byte(i)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rel, err, dq;
    void'($urandom(32'h5EED));
    model_clr = 1;
    repeat (3) @(negedge clk);
    #1;
    check(cpu_reset_n == 0 && arm_error == 0, "R1", "reset state", {cpu_reset_n, arm_error}, 0);
    check(ram_sel == 0 && card_sel == 0, "R10", "reset steering", {ram_sel, card_sel}, 0);
    @(negedge clk);
    rst_n = 1; model_clr = 0;

    card_boot(0, 1);
    probe(16'h00FF, 1, "R7");
    probe(16'h0100, 1, "R7");
    probe(16'h0000, 1, "R7");
    for (int k = 0; k < 20; k++) probe(16'($urandom_range(0, 16'h03FF)), 1, "R7");

    boot_sel = 0;
    repeat (3) @(negedge clk);
    #1;
    check(strap_en == 0, "R2", "strap after jumper change", strap_en, 0);
    probe(16'h0010, 1, "R2");

    io_write(8'h21);
    probe(16'h0010, 1, "R8");
    io_write(PORT);
    probe(16'h0010, 0, "R8");
    for (int k = 0; k < 10; k++) probe(16'($urandom_range(0, 16'h01FF)), 0, "R8");

    card_boot(3, 2);
    probe(16'h0000, 1, "R8");

    for (int k = 0; k < 6; k++) begin
      card_boot($urandom_range(0, 25), $urandom_range(1, 25));
      probe(16'($urandom_range(0, 16'h00FF)), 1, "R7");
    end

    // strap boot
    restart(0, 0, 1);
    begin
      int n;
      rel = -1;
      for (n = 0; n < 200; n++) begin
        @(negedge clk); #1;
        if (cpu_reset_n) begin rel = n; break; end
        if (!(strap_en && strap_data == 8'h40))
          check(0, "R9", "strap during hold", {strap_en, strap_data}, 9'h140);
      end
    end
    check(rel == HOLD, "R9", "strap release cycle", rel, HOLD);
    check(strap_en == 1 && strap_data == 8'h40, "R9", "strap at release", {strap_en, strap_data}, 9'h140);
    check(hold_strobes == 0, "R9", "card strobes in strap mode", hold_strobes, 0);
    @(negedge clk); #1;
    check(strap_en == 0, "R9", "strap after release", strap_en, 0);
    probe(16'h0010, 0, "R9");
    boot_sel = 1;
    repeat (2) @(negedge clk);
    probe(16'h0020, 0, "R2");

    // idle timeout
    hang_bsy = 1;
    restart(1, 0, 1);
    run_hold(rel, err, dq);
    check(err == TMO && rel < 0, "R6", "idle timeout cycle", err, TMO);
    repeat (20) @(negedge clk);
    #1;
    check(arm_error == 1 && cpu_reset_n == 0, "R6", "error held", {arm_error, cpu_reset_n}, 2'b10);
    hang_bsy = 0;
    card_boot(2, 2);
    check(arm_error == 0, "R1", "restart clears error", arm_error, 0);

    // data-ready timeout
    hang_drq = 1;
    restart(1, 0, 1);
    run_hold(rel, err, dq);
    check(err == TMO + 7 && rel < 0, "R6", "drq timeout cycle", err, TMO + 7);
    hang_drq = 0;
    card_boot(1, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule